// File: doc/BRIEF.md
# Fault-injectable test RAM

A small single-port, bit-wide RAM whose storage can be made to misbehave on purpose, used as the device under test when memory self-test sequencers are developed. Each cycle the port performs either one write (`we_i` high) or one read (`we_i` low). A read returns its data on `rdata_o` one clock later.

A fault selection set on the configuration inputs arms one functional fault at a time. The selection gives the fault kind, a victim cell, an aggressor cell, a polarity and a forced value. The supported faults fall into three groups. Single-cell faults are stuck-at and transition faults. Two-cell coupling faults come in inversion, idempotent and state forms. Address-path faults cover an address that selects nothing, a cell that no address can reach, and an address that selects two cells. The configuration may change at any cycle and takes effect in that same cycle. With the kind set to none the block is ideal storage.

Top module: `fault_ram`

## Requirements
- R1: With `flt_kind_i` = 0 (no fault), a read of an address returns the last value written there, on `rdata_o` after the next rising edge. During a write cycle `rdata_o` keeps its previous value.
- R2: Kind 1 (stuck-at): the victim cell always reads as `flt_force_i`, and writes to it have no effect.
- R3: Kind 2 (transition): with `flt_pol_i` = 1, a victim holding 0 ignores a write of 1. With `flt_pol_i` = 0, a victim holding 1 ignores a write of 0. All other writes to it behave normally.
- R4: Kind 3 (inversion coupling): each write that moves the aggressor 0→1 (`flt_pol_i` = 1) or 1→0 (`flt_pol_i` = 0) inverts the victim in the same edge. A write that causes no transition, or causes the opposite transition, leaves the victim unchanged.
- R5: Kind 4 (idempotent coupling): the armed aggressor transition, as in R4, sets the victim to `flt_force_i`. Other aggressor writes leave the victim alone.
- R6: Kind 5 (state coupling): while the aggressor holds the value `flt_pol_i`, the victim reads `flt_force_i` and writes to it are overridden. After the aggressor leaves that value, the victim keeps its last content and accepts writes again.
- R7: Coupling acts in one direction only: writes and transitions of the victim never change the aggressor.
- R8: Kind 6 (dead address): the victim address selects no cell. Its reads return `flt_force_i`, and its writes are discarded. The cell with that index keeps its content.
- R9: Kind 7 (orphan cell): the victim address is routed to the aggressor cell for both reads and writes. The victim cell cannot be reached and keeps its content.
- R10: Kind 8 (double select): the aggressor address selects the aggressor cell and the victim cell together. A write stores into both, and a read returns the AND of the two.
- R11: Asynchronous active-low reset clears every cell and `rdata_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | 1 | Write data |
| we_i | input | 1 | 1 = write, 0 = read |
| rdata_o | output | 1 | Registered read data |
| flt_kind_i | input | 4 | Fault kind code (0..8, see R1 to R10) |
| flt_victim_i | input | ADDR_W | Victim cell or address |
| flt_aggr_i | input | ADDR_W | Aggressor cell or address |
| flt_pol_i | input | 1 | Transition direction or aggressor state |
| flt_force_i | input | 1 | Stuck, forced or floating value |

## Verification
In a coupling fault, the aggressor's write and the victim's disturbance fall in the same clock edge. The victim's next value is derived from the aggressor's nominal next value, not from its stored value. The bench provokes this by writing the aggressor in the armed direction, then in the opposite direction, then with no change, and it reads the victim after each write. A state coupling case also writes the victim while the aggressor sits in its trigger state, which shows that the override wins over the write landing on that edge.

// File: rtl/fram_pkg.sv
package fram_pkg;
  typedef enum logic [3:0] {
    FK_NONE    = 4'd0,
    FK_STUCK   = 4'd1,
    FK_TRANS   = 4'd2,
    FK_CINV    = 4'd3,
    FK_CIDEM   = 4'd4,
    FK_CSTATE  = 4'd5,
    FK_ADEAD   = 4'd6,
    FK_AORPHAN = 4'd7,
    FK_AMULTI  = 4'd8
  } fault_kind_e;
endpackage

// File: rtl/fram_decode.sv
module fram_decode
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  fault_kind_e       kind_i,
  input  logic [ADDR_W-1:0] victim_i,
  input  logic [ADDR_W-1:0] aggr_i,
  output logic [(1<<ADDR_W)-1:0] sel_o
);
  localparam int DEPTH = 1 << ADDR_W;

  always_comb begin
    sel_o = '0;
    sel_o[addr_i] = 1'b1;
    unique case (kind_i)
      FK_ADEAD:   if (addr_i == victim_i) sel_o = '0;
      FK_AORPHAN: if (addr_i == victim_i) begin
                    sel_o = '0;
                    sel_o[aggr_i] = 1'b1;
                  end
      FK_AMULTI:  if (addr_i == aggr_i) sel_o[victim_i] = 1'b1;
      default: ;
    endcase
  end

  // R1
  clean_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FK_NONE) |-> $onehot(sel_o));

  // R10
  multi_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FK_AMULTI && addr_i == aggr_i && aggr_i != victim_i)
      |-> ($countones(sel_o) == 2));

  // R9
  orphan_unreach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FK_AORPHAN && victim_i != aggr_i) |-> !sel_o[victim_i]);

  logic unused_depth;
  assign unused_depth = (DEPTH == 0);
endmodule

// File: rtl/fram_array.sv
module fram_array
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   wdata_i,
  input  logic [(1<<ADDR_W)-1:0] sel_i,
  input  fault_kind_e            kind_i,
  input  logic [ADDR_W-1:0]      victim_i,
  input  logic [ADDR_W-1:0]      aggr_i,
  input  logic                   pol_i,
  input  logic                   force_i,
  output logic [(1<<ADDR_W)-1:0] eff_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem_q, nom, nxt;
  logic agg_old, agg_new, trig;

  for (genvar c = 0; c < DEPTH; c++) begin : g_cell
    assign nom[c] = (we_i && sel_i[c]) ? wdata_i : mem_q[c];
  end

  assign agg_old = mem_q[aggr_i];
  assign agg_new = nom[aggr_i];
  // armed edge on the aggressor, seen within the current write
  assign trig = pol_i ? (!agg_old && agg_new) : (agg_old && !agg_new);

  always_comb begin
    nxt = nom;
    unique case (kind_i)
      FK_STUCK:  nxt[victim_i] = force_i;
      FK_TRANS:  if (we_i && sel_i[victim_i] && (mem_q[victim_i] == !pol_i)
                     && (wdata_i == pol_i))
                   nxt[victim_i] = mem_q[victim_i];
      FK_CINV:   if (trig) nxt[victim_i] = !mem_q[victim_i];
      FK_CIDEM:  if (trig) nxt[victim_i] = force_i;
      FK_CSTATE: if (agg_new == pol_i) nxt[victim_i] = force_i;
      default: ;
    endcase
  end

  // read view: overrides that must show before the first edge after arming
  always_comb begin
    eff_o = mem_q;
    unique case (kind_i)
      FK_STUCK:  eff_o[victim_i] = force_i;
      FK_CSTATE: if (mem_q[aggr_i] == pol_i) eff_o[victim_i] = force_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else         mem_q <= nxt;
  end

  // R3
  trans_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == FK_TRANS && we_i && sel_i[victim_i] && mem_q[victim_i] != pol_i
     && wdata_i == pol_i)
      |=> (mem_q[$past(victim_i)] == $past(mem_q[victim_i])));

  // R7
  one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i inside {FK_CINV, FK_CIDEM, FK_CSTATE} && we_i && sel_i[victim_i]
     && !sel_i[aggr_i] && victim_i != aggr_i)
      |=> (mem_q[$past(aggr_i)] == $past(mem_q[aggr_i])));
endmodule

// File: rtl/fram_read.sv
module fram_read #(
  parameter int ADDR_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [(1<<ADDR_W)-1:0] sel_i,
  input  logic [(1<<ADDR_W)-1:0] eff_i,
  input  logic                   float_i,
  output logic                   rdata_o
);
  logic rd_val;

  // no cell selected: floating value; several cells: wired AND
  assign rd_val = (sel_i == '0) ? float_i : &(eff_i | ~sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= 1'b0;
    else if (!we_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  input  logic              we_i,
  output logic              rdata_o,
  input  logic [3:0]        flt_kind_i,
  input  logic [ADDR_W-1:0] flt_victim_i,
  input  logic [ADDR_W-1:0] flt_aggr_i,
  input  logic              flt_pol_i,
  input  logic              flt_force_i
);
  localparam int DEPTH = 1 << ADDR_W;

  fault_kind_e      kind;
  logic [DEPTH-1:0] sel, eff;

  assign kind = fault_kind_e'(flt_kind_i);

  fram_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i, .rst_ni, .addr_i,
    .kind_i(kind), .victim_i(flt_victim_i), .aggr_i(flt_aggr_i),
    .sel_o(sel)
  );

  fram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .we_i, .wdata_i,
    .sel_i(sel), .kind_i(kind), .victim_i(flt_victim_i), .aggr_i(flt_aggr_i),
    .pol_i(flt_pol_i), .force_i(flt_force_i), .eff_o(eff)
  );

  fram_read #(.ADDR_W(ADDR_W)) u_read (
    .clk_i, .rst_ni, .we_i, .sel_i(sel), .eff_i(eff),
    .float_i(flt_force_i), .rdata_o
  );

  // R1
  write_holds_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> $stable(rdata_o));

  // R2
  stuck_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == FK_STUCK && !we_i && addr_i == flt_victim_i)
      |=> (rdata_o == $past(flt_force_i)));

  // R8
  dead_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == FK_ADEAD && !we_i && addr_i == flt_victim_i)
      |=> (rdata_o == $past(flt_force_i)));
endmodule

// File: tb/fault_ram_bench.sv
module fault_ram_bench;
  localparam int AW = 4;

  typedef struct packed {
    logic [3:0] kind;
    logic [3:0] vic;
    logic [3:0] agg;
    logic       pol;
    logic       frc;
    logic       we;
    logic [3:0] addr;
    logic       wd;
    logic       chk;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 60;
  // kind vic agg pol frc we addr wd chk exp req
  localparam vec_t VEC [NV] = '{
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd3,1'b1,1'b0,1'b0,4'd1},   // R1
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd3,1'b0,1'b1,1'b1,4'd1},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd4,1'b0,1'b1,1'b0,4'd1},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd3,1'b0,1'b0,1'b0,4'd1},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd3,1'b0,1'b1,1'b0,4'd1},
    '{4'd1,4'd5,4'd0,1'b0,1'b1,1'b0,4'd5,1'b0,1'b1,1'b1,4'd2},   // R2
    '{4'd1,4'd5,4'd0,1'b0,1'b1,1'b1,4'd5,1'b0,1'b0,1'b0,4'd2},
    '{4'd1,4'd5,4'd0,1'b0,1'b1,1'b0,4'd5,1'b0,1'b1,1'b1,4'd2},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd5,1'b0,1'b0,1'b0,4'd2},
    '{4'd2,4'd6,4'd0,1'b1,1'b0,1'b1,4'd6,1'b1,1'b0,1'b0,4'd3},   // R3 up
    '{4'd2,4'd6,4'd0,1'b1,1'b0,1'b0,4'd6,1'b0,1'b1,1'b0,4'd3},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd7,1'b1,1'b0,1'b0,4'd3},
    '{4'd2,4'd7,4'd0,1'b0,1'b0,1'b1,4'd7,1'b0,1'b0,1'b0,4'd3},   // R3 down
    '{4'd2,4'd7,4'd0,1'b0,1'b0,1'b0,4'd7,1'b0,1'b1,1'b1,4'd3},
    '{4'd2,4'd6,4'd0,1'b0,1'b0,1'b1,4'd6,1'b1,1'b0,1'b0,4'd3},   // R3 normal 0->1
    '{4'd2,4'd6,4'd0,1'b0,1'b0,1'b0,4'd6,1'b0,1'b1,1'b1,4'd3},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd7,1'b0,1'b0,1'b0,4'd3},
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b1,4'd9,1'b1,1'b0,1'b0,4'd4},   // R4 rise
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b0,4'd2,1'b0,1'b1,1'b1,4'd4},
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b1,4'd9,1'b1,1'b0,1'b0,4'd4},   // R4 no change
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b0,4'd2,1'b0,1'b1,1'b1,4'd4},
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b1,4'd9,1'b0,1'b0,1'b0,4'd4},   // R4 fall
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b0,4'd2,1'b0,1'b1,1'b1,4'd4},
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b1,4'd2,1'b0,1'b0,1'b0,4'd7},   // R7
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b1,4'd2,1'b1,1'b0,1'b0,4'd7},
    '{4'd3,4'd2,4'd9,1'b1,1'b0,1'b0,4'd9,1'b0,1'b1,1'b0,4'd7},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd2,1'b0,1'b0,1'b0,4'd7},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd12,1'b1,1'b0,1'b0,4'd5},  // R5
    '{4'd4,4'd11,4'd12,1'b0,1'b1,1'b1,4'd12,1'b0,1'b0,1'b0,4'd5},
    '{4'd4,4'd11,4'd12,1'b0,1'b1,1'b0,4'd11,1'b0,1'b1,1'b1,4'd5},
    '{4'd4,4'd11,4'd12,1'b0,1'b1,1'b1,4'd11,1'b0,1'b0,1'b0,4'd5},
    '{4'd4,4'd11,4'd12,1'b0,1'b1,1'b1,4'd12,1'b1,1'b0,1'b0,4'd5},
    '{4'd4,4'd11,4'd12,1'b0,1'b1,1'b0,4'd11,1'b0,1'b1,1'b0,4'd5},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd12,1'b0,1'b0,1'b0,4'd5},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b0,4'd13,1'b0,1'b1,1'b0,4'd6}, // R6
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b1,4'd14,1'b1,1'b0,1'b0,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b0,4'd13,1'b0,1'b1,1'b1,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b1,4'd13,1'b0,1'b0,1'b0,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b0,4'd13,1'b0,1'b1,1'b1,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b1,4'd14,1'b0,1'b0,1'b0,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b0,4'd13,1'b0,1'b1,1'b1,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b1,4'd13,1'b0,1'b0,1'b0,4'd6},
    '{4'd5,4'd13,4'd14,1'b1,1'b1,1'b0,4'd13,1'b0,1'b1,1'b0,4'd6},
    '{4'd6,4'd8,4'd0,1'b0,1'b1,1'b0,4'd8,1'b0,1'b1,1'b1,4'd8},    // R8
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd8,1'b1,1'b0,1'b0,4'd8},
    '{4'd6,4'd8,4'd0,1'b0,1'b1,1'b1,4'd8,1'b0,1'b0,1'b0,4'd8},
    '{4'd6,4'd8,4'd0,1'b0,1'b0,1'b0,4'd8,1'b0,1'b1,1'b0,4'd8},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd8,1'b0,1'b1,1'b1,4'd8},
    '{4'd7,4'd1,4'd10,1'b0,1'b0,1'b1,4'd1,1'b1,1'b0,1'b0,4'd9},   // R9
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd1,1'b0,1'b1,1'b0,4'd9},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd10,1'b0,1'b1,1'b1,4'd9},
    '{4'd7,4'd1,4'd10,1'b0,1'b0,1'b0,4'd1,1'b0,1'b1,1'b1,4'd9},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd15,1'b1,1'b0,1'b0,4'd10},  // R10
    '{4'd8,4'd15,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,1'b0,4'd10},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd15,1'b0,1'b0,1'b0,4'd10},
    '{4'd8,4'd15,4'd0,1'b0,1'b0,1'b1,4'd0,1'b1,1'b0,1'b0,4'd10},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd15,1'b0,1'b1,1'b1,4'd10},
    '{4'd8,4'd15,4'd0,1'b0,1'b0,1'b0,4'd0,1'b0,1'b1,1'b1,4'd10},
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b1,4'd15,1'b0,1'b1,1'b1,4'd1},   // R1 write holds rdata
    '{4'd0,4'd0,4'd0,1'b0,1'b0,1'b0,4'd15,1'b0,1'b1,1'b0,4'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wd = 1'b0;
  logic          we = 1'b0;
  logic          rd;
  logic [3:0]    kind = '0;
  logic [AW-1:0] vic = '0;
  logic [AW-1:0] agg = '0;
  logic          pol = 1'b0;
  logic          frc = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fault_ram #(.ADDR_W(AW)) u_fault_ram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wd), .we_i(we),
    .rdata_o(rd), .flt_kind_i(kind), .flt_victim_i(vic), .flt_aggr_i(agg),
    .flt_pol_i(pol), .flt_force_i(frc)
  );

  task automatic check(input logic act, input logic exp, input int req, input int idx);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d step %0d: rdata_o=%b expected %b", req, idx, act, exp);
    end
  endtask

  initial begin
    #2;
    check(rd, 1'b0, 11, -1);  // R11 reset value
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      kind = VEC[i].kind; vic = VEC[i].vic; agg = VEC[i].agg;
      pol = VEC[i].pol; frc = VEC[i].frc; we = VEC[i].we;
      addr = VEC[i].addr; wd = VEC[i].wd;
      @(posedge clk);
      #1;
      if (VEC[i].chk) check(rd, VEC[i].exp, int'(VEC[i].req), i);
    end
    // R11: reset mid-run clears cell 0 (set by the double-select write) and rdata
    @(negedge clk);
    kind = '0; we = 1'b0; addr = 4'd0;
    @(posedge clk);
    #1;
    check(rd, 1'b1, 10, 100);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd, 1'b0, 11, 101);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(rd, 1'b0, 11, 102);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule